// File: doc/BRIEF.md
# Flash Erase Control Sequencer

This block sits between a simple CPU bus and a small on-chip flash array. It holds the flash control register and a block-protect register. It watches each software step of a page erase or a whole-array erase. It lets the high-voltage enable turn on only after the steps have arrived in the right order and the minimum waits have passed. When the steps are correct, it drives the array with a high-voltage enable, an erase strobe, a whole-array select and the latched page number.

Each wait is a parameter in clock cycles. A down-counter is reloaded at every timed step, and the step is "met" once the counter has reached zero. Any step that arrives out of order or too early is refused. Such a step sets a sticky sequence-error output and cancels the sequence in progress. The program (byte write) datapath is out of scope. The program bit is stored and interlocked, but it never allows high voltage.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, the control register, the protect register, `hv_en_o`, `erase_strobe_o`, `mass_o`, `page_o` and `seq_err_o` are all 0.
- R2: Reading the control register returns bit 3 = high-voltage enable, bit 2 = whole-array select, bit 1 = erase select and bit 0 = program select. Bits 7..4 always read 0. Read data appears one cycle after the read strobe.
- R3: The erase bit can be set only if the program bit is 0 and the same write does not also set program. The same rule applies to the program bit with respect to erase. Clearing either bit is always accepted. The two bits are never 1 together.
- R4: The accepted order is as follows. First, a control write sets erase while erase was 0 and high voltage is off (arming). Second, the protect register is read. Third, a write lands inside flash space (`FLASH_LO`..`FLASH_HI`), which latches the page number `addr[ADDR_W-1:PAGE_LG]`. Fourth, after the setup wait, a control write with bit 3 = 1 and erase kept at 1 turns on `hv_en_o`.
- R5: A request to set high voltage anywhere other than the met setup step is ignored and sets `seq_err_o`. This includes a request from idle or with only the program bit set.
- R6: The setup wait is met only when `SETUP_CYC` cycles have elapsed after the page write. The high-voltage write must come at least `SETUP_CYC`+1 edges after that write. An earlier request is refused and counts as an error.
- R7: `erase_strobe_o` is 1 exactly while high voltage and erase are both on in the erase step. It falls at the write that clears erase.
- R8: Clearing erase before `ERASE_CYC` cycles have passed with high voltage on still clears erase and drops the strobe, but sets `seq_err_o`.
- R9: After erase is cleared, clearing high voltage before `HOLD_CYC` cycles sets `seq_err_o`. Clearing high voltage is always honoured, and it returns the sequencer to idle.
- R10: A flash write after arming but before the protect read sets `seq_err_o` and cancels the arming, so a later high-voltage request is refused.
- R11: Only the first flash write after the protect read latches the page. Later flash writes in the same sequence leave `page_o` unchanged.
- R12: The whole-array select bit drives `mass_o` and follows the same sequence as a page erase.
- R13: While high voltage is on, a control write cannot change the whole-array or program bits or set erase. It can only clear erase or high voltage.
- R14: The protect register is an 8-bit read/write register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |
| hv_en_o | output | 1 | High-voltage enable to the array |
| erase_strobe_o | output | 1 | Erase pulse to the array |
| mass_o | output | 1 | Whole-array erase select |
| page_o | output | ADDR_W-PAGE_LG | Latched page number |
| seq_err_o | output | 1 | Sticky sequence error |

## Verification
Some properties are checked on every cycle. These are: erase and program are never both set; the strobe is never high without high voltage and erase; high voltage rises only from a met setup step; the error flag never clears on its own; the mode bits stay frozen while high voltage is on; the latched page does not move during the setup wait; and the counter steps down by one. Only the bench scenarios can show the exact cycle on which each wait becomes met, the refusal of out-of-order steps, the value returned on reads and the page number latched from a given address.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_PROT  = 3'd2,
    ST_SETUP = 3'd3,
    ST_ERASE = 3'd4,
    ST_HOLD  = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic hv;
    logic mass;
    logic erase;
    logic pgm;
  } ctrl_t;
endpackage

// File: rtl/flash_seq_decode.sv
module flash_seq_decode #(
  parameter int ADDR_W = 16,
  parameter int PAGE_LG = 6,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFE08,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 16'hFF7E,
  parameter logic [ADDR_W-1:0] FLASH_LO  = 16'hE000,
  parameter logic [ADDR_W-1:0] FLASH_HI  = 16'hFDFF
) (
  input  logic [ADDR_W-1:0]         addr,
  output logic                      ctrl_hit,
  output logic                      prot_hit,
  output logic                      flash_hit,
  output logic [ADDR_W-PAGE_LG-1:0] page
);
  always_comb begin
    ctrl_hit  = (addr == CTRL_ADDR);
    prot_hit  = (addr == PROT_ADDR);
    flash_hit = (addr >= FLASH_LO) && (addr <= FLASH_HI);
    page      = addr[ADDR_W-1:PAGE_LG];
  end
endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R6: the wait counter steps down by exactly one per cycle
  a_r6_count_down: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int PAGE_W    = 10,
  parameter int TW        = 8,
  parameter int SETUP_CYC = 80,
  parameter int ERASE_CYC = 8000,
  parameter int HOLD_CYC  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [3:0]        wdata,
  input  logic              prot_rd,
  input  logic              flash_wr,
  input  logic [PAGE_W-1:0] flash_page,
  input  logic              tmr_done,
  output logic              tmr_load,
  output logic [TW-1:0]     tmr_val,
  output ctrl_t             ctrl_q,
  output logic [PAGE_W-1:0] page_q,
  output logic              strobe_q,
  output logic              err_q
);
  localparam logic [TW-1:0] SETUP_V = TW'(SETUP_CYC);
  localparam logic [TW-1:0] ERASE_V = TW'(ERASE_CYC);
  localparam logic [TW-1:0] HOLD_V  = TW'(HOLD_CYC);

  seq_state_e st_q, st_n;
  ctrl_t      ctrl_n;
  logic       err_set, page_ld;

  always_comb begin
    ctrl_n   = ctrl_q;
    st_n     = st_q;
    err_set  = 1'b0;
    page_ld  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (ctrl_wr) begin
      if (ctrl_q.hv) begin
        ctrl_n.erase = ctrl_q.erase & wdata[1];
        if (!wdata[3]) begin
          ctrl_n.hv = 1'b0;
          st_n      = ST_IDLE;
          if (!(st_q == ST_HOLD && tmr_done)) err_set = 1'b1;
        end else if (ctrl_q.erase && !wdata[1]) begin
          st_n     = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = HOLD_V;
          if (!(st_q == ST_ERASE && tmr_done)) err_set = 1'b1;
        end
      end else begin
        ctrl_n.mass  = wdata[2];
        ctrl_n.erase = wdata[1] & (ctrl_q.erase | (~ctrl_q.pgm & ~wdata[0]));
        ctrl_n.pgm   = wdata[0] & (ctrl_q.pgm | (~ctrl_q.erase & ~wdata[1]));
        if (wdata[3]) begin
          if (st_q == ST_SETUP && tmr_done && ctrl_n.erase) begin
            ctrl_n.hv = 1'b1;
            st_n      = ST_ERASE;
            tmr_load  = 1'b1;
            tmr_val   = ERASE_V;
          end else begin
            err_set = 1'b1;
            st_n    = ST_IDLE;
          end
        end else if (st_q == ST_IDLE) begin
          if (!ctrl_q.erase && ctrl_n.erase) st_n = ST_ARMED;
        end else if (!ctrl_n.erase) begin
          st_n = ST_IDLE;
        end
      end
    end else if (prot_rd && st_q == ST_ARMED) begin
      st_n = ST_PROT;
    end else if (flash_wr) begin
      if (st_q == ST_PROT) begin
        st_n     = ST_SETUP;
        page_ld  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = SETUP_V;
      end else if (st_q == ST_ARMED) begin
        err_set = 1'b1;
        st_n    = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      ctrl_q   <= '0;
      page_q   <= '0;
      strobe_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st_q     <= st_n;
      ctrl_q   <= ctrl_n;
      strobe_q <= (st_n == ST_ERASE);
      if (page_ld) page_q <= flash_page;
      if (err_set) err_q <= 1'b1;
    end
  end

  // R3: erase and program never coexist
  a_r3_interlock: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_q.erase && ctrl_q.pgm));
  // R7: strobe only with high voltage and erase on
  a_r7_strobe_gated: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> (ctrl_q.hv && ctrl_q.erase));
  // R6: high voltage rises only from a met setup step
  a_r6_hv_after_setup: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_q.hv) |-> $past(st_q == ST_SETUP && tmr_done));
  // R9: error flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  // R13: mode bits frozen while high voltage stays on
  a_r13_hv_freeze: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.hv && $past(ctrl_q.hv)) |-> ($stable(ctrl_q.mass) && $stable(ctrl_q.pgm)));
  // R11: page number holds during the setup wait
  a_r11_page_hold: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SETUP && $past(st_q == ST_SETUP)) |-> $stable(page_q));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAGE_LG   = 6,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFE08,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 16'hFF7E,
  parameter logic [ADDR_W-1:0] FLASH_LO  = 16'hE000,
  parameter logic [ADDR_W-1:0] FLASH_HI  = 16'hFDFF,
  parameter int SETUP_CYC = 80,
  parameter int ERASE_CYC = 8000,
  parameter int HOLD_CYC  = 40
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [7:0]                bus_wdata,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  output logic [7:0]                bus_rdata,
  output logic                      hv_en_o,
  output logic                      erase_strobe_o,
  output logic                      mass_o,
  output logic [ADDR_W-PAGE_LG-1:0] page_o,
  output logic                      seq_err_o
);
  localparam int PAGE_W = ADDR_W - PAGE_LG;
  localparam int MAX_AB = (SETUP_CYC > ERASE_CYC) ? SETUP_CYC : ERASE_CYC;
  localparam int MAX_C  = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
  localparam int TW     = $clog2(MAX_C + 1);

  logic              ctrl_hit, prot_hit, flash_hit;
  logic [PAGE_W-1:0] dec_page;
  logic              tmr_load, tmr_done;
  logic [TW-1:0]     tmr_val;
  ctrl_t             ctrl_q;
  logic [7:0]        prot_q;

  flash_seq_decode #(
    .ADDR_W(ADDR_W), .PAGE_LG(PAGE_LG), .CTRL_ADDR(CTRL_ADDR),
    .PROT_ADDR(PROT_ADDR), .FLASH_LO(FLASH_LO), .FLASH_HI(FLASH_HI)
  ) u_dec (
    .addr(bus_addr), .ctrl_hit(ctrl_hit), .prot_hit(prot_hit),
    .flash_hit(flash_hit), .page(dec_page)
  );

  flash_seq_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  flash_seq_ctrl #(
    .PAGE_W(PAGE_W), .TW(TW), .SETUP_CYC(SETUP_CYC),
    .ERASE_CYC(ERASE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .ctrl_wr(bus_wr && ctrl_hit), .wdata(bus_wdata[3:0]),
    .prot_rd(bus_rd && prot_hit), .flash_wr(bus_wr && flash_hit),
    .flash_page(dec_page), .tmr_done(tmr_done),
    .tmr_load(tmr_load), .tmr_val(tmr_val),
    .ctrl_q(ctrl_q), .page_q(page_o), .strobe_q(erase_strobe_o), .err_q(seq_err_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && prot_hit) prot_q <= bus_wdata;
      if (bus_rd) begin
        if (ctrl_hit)      bus_rdata <= {4'b0000, ctrl_q};
        else if (prot_hit) bus_rdata <= prot_q;
        else               bus_rdata <= '0;
      end
    end
  end

  assign hv_en_o = ctrl_q.hv;
  assign mass_o  = ctrl_q.mass;

  // R2: upper control bits are never reported as set
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && ctrl_hit) |-> (bus_rdata[7:4] == 4'b0000));
endmodule

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;
  localparam int SETUP = 8;
  localparam int ERASE = 20;
  localparam int HOLD  = 4;
  localparam logic [15:0] CTRL = 16'hFE08;
  localparam logic [15:0] PROT = 16'hFF7E;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        hv_en_o, erase_strobe_o, mass_o, seq_err_o;
  logic [9:0]  page_o;
  int          n_tests = 0, n_fail = 0;

  flash_erase_seq #(.SETUP_CYC(SETUP), .ERASE_CYC(ERASE), .HOLD_CYC(HOLD)) u_flash_erase_seq (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .hv_en_o(hv_en_o), .erase_strobe_o(erase_strobe_o), .mass_o(mass_o),
    .page_o(page_o), .seq_err_o(seq_err_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic to_hv(input logic [15:0] fa, input logic [7:0] arm);
    logic [7:0] d;
    do_reset();
    wr(CTRL, arm);
    rd(PROT, d);
    wr(fa, 8'h55);
    idle(SETUP);
    wr(CTRL, arm | 8'h08);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    rd(CTRL, d); chk("R1 ctrl", d, 0);
    rd(PROT, d); chk("R1 prot", d, 0);
    chk("R1 outs", {hv_en_o, erase_strobe_o, mass_o, seq_err_o, page_o}, 0);
  endtask

  task automatic t_prot_rw();
    logic [7:0] d;
    do_reset();
    wr(PROT, 8'hA5); rd(PROT, d); chk("R14 prot rw", d, 8'hA5);
  endtask

  task automatic t_interlock();
    logic [7:0] d;
    do_reset();
    wr(CTRL, 8'h03); rd(CTRL, d); chk("R3 both set", d, 8'h00);
    wr(CTRL, 8'h02); rd(CTRL, d); chk("R3 erase set", d, 8'h02);
    wr(CTRL, 8'h03); rd(CTRL, d); chk("R3 pgm with erase", d, 8'h02);
    wr(CTRL, 8'h01); rd(CTRL, d); chk("R3 pgm while erase", d, 8'h00);
    wr(CTRL, 8'hF1); rd(CTRL, d); chk("R2 upper zero", d, 8'h01);
    wr(CTRL, 8'h02); rd(CTRL, d); chk("R3 erase while pgm", d, 8'h00);
    wr(CTRL, 8'h04); rd(CTRL, d); chk("R2 mass bit", d, 8'h04);
    chk("R12 mass out", mass_o, 1);
  endtask

  task automatic t_page_seq();
    logic [7:0] d;
    to_hv(16'hE0C5, 8'h02);
    chk("R4 hv on", hv_en_o, 1);
    chk("R4 page", page_o, 10'(16'hE0C5 >> 6));
    chk("R7 strobe on", erase_strobe_o, 1);
    rd(CTRL, d); chk("R2 ctrl hv", d, 8'h0A);
    chk("R4 no err", seq_err_o, 0);
    idle(ERASE);
    wr(CTRL, 8'h08);
    chk("R7 strobe off", erase_strobe_o, 0);
    chk("R8 in time", {hv_en_o, seq_err_o}, 2'b10);
    idle(HOLD);
    wr(CTRL, 8'h00);
    chk("R9 hold met", {hv_en_o, seq_err_o}, 2'b00);
  endtask

  task automatic t_early_hv();
    logic [7:0] d;
    do_reset();
    wr(CTRL, 8'h02); rd(PROT, d); wr(16'hE100, 8'h00);
    idle(SETUP - 1);
    wr(CTRL, 8'h0A);
    chk("R6 early hv", {hv_en_o, seq_err_o}, 2'b01);
  endtask

  task automatic t_skip_prot();
    logic [7:0] d;
    do_reset();
    wr(CTRL, 8'h02); wr(16'hE100, 8'h00);
    chk("R10 err", seq_err_o, 1);
    rd(PROT, d); wr(16'hE100, 8'h00); idle(SETUP);
    wr(CTRL, 8'h0A);
    chk("R10 cancelled", hv_en_o, 0);
  endtask

  task automatic t_hv_refused();
    logic [7:0] d;
    do_reset();
    wr(CTRL, 8'h08);
    chk("R5 idle hv", {hv_en_o, seq_err_o}, 2'b01);
    rd(CTRL, d); chk("R5 ctrl", d, 8'h00);
    do_reset();
    wr(CTRL, 8'h01); wr(CTRL, 8'h09);
    chk("R5 pgm hv", {hv_en_o, seq_err_o}, 2'b01);
  endtask

  task automatic t_page_latch();
    logic [7:0] d;
    do_reset();
    wr(CTRL, 8'h02); rd(PROT, d);
    wr(16'hE0C5, 8'h00); wr(16'hF012, 8'h00);
    idle(SETUP);
    wr(CTRL, 8'h0A);
    chk("R11 first page", page_o, 10'(16'hE0C5 >> 6));
    chk("R11 hv", hv_en_o, 1);
  endtask

  task automatic t_early_erase_clear();
    to_hv(16'hE040, 8'h02);
    idle(3);
    wr(CTRL, 8'h08);
    chk("R8 early clear", {hv_en_o, erase_strobe_o, seq_err_o}, 3'b101);
  endtask

  task automatic t_early_hv_clear();
    to_hv(16'hE040, 8'h02);
    idle(ERASE); wr(CTRL, 8'h08);
    idle(HOLD - 2); wr(CTRL, 8'h00);
    chk("R9 early hv clear", {hv_en_o, seq_err_o}, 2'b01);
  endtask

  task automatic t_hv_lock();
    logic [7:0] d;
    to_hv(16'hE080, 8'h02);
    wr(CTRL, 8'h0E); rd(CTRL, d); chk("R13 mass locked", d, 8'h0A);
    wr(CTRL, 8'h0B); rd(CTRL, d); chk("R13 pgm locked", d, 8'h0A);
    chk("R13 mass out", mass_o, 0);
  endtask

  task automatic t_mass();
    to_hv(16'hF000, 8'h06);
    chk("R12 mass erase", {hv_en_o, erase_strobe_o, mass_o, seq_err_o}, 4'b1110);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_prot_rw();
    t_interlock();
    t_page_seq();
    t_early_hv();
    t_skip_prot();
    t_hv_refused();
    t_page_latch();
    t_early_erase_clear();
    t_early_hv_clear();
    t_hv_lock();
    t_mass();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule